// File: doc/BRIEF.md
# Memory-Mapped Configuration Window Decoder

This block sits in the root complex and decides, for every CPU request, whether it is a configuration access. A memory request that falls inside a relocatable configuration window is split into bus, device, function and register-offset coordinates. The window holds 4KB of registers per function, 8 functions per device and 32 devices per bus, so its size sets how many buses it can reach. Any other memory request is flagged for ordinary forwarding.

A second path serves the older port-based mechanism. Software writes an address dword to I/O port 0xCF8. A later access to the data dword at 0xCFC then reaches the first 256 bytes of the same function's registers. Each request gives, one cycle later, at most one of three results: a configuration request, a pass-through indication, or a reject. A request that only loads the address latch gives none of them.

The window register is loaded from a programming strobe carrying a 36-bit base, a size code and an enable.

Top module: `cfgwin_decoder`

## Requirements
- R1: After reset the window is disabled and the port latch's enable bit (bit 31) is clear. So every memory request and every access to the 0xCFC data dword is passed through.
- R2: A pulse on `win_set` loads base, size and enable only when the base's low 28 bits are zero. If they are not zero, all three keep their old values.
- R3: A memory request whose address bits [ADDR_W-1:28] equal the zero-extended base bits [35:28], with the window enabled and the size fitting, gives a configuration request. The fields are bus = addr[27:20], device = addr[19:15], function = addr[14:12] and register = addr[11:0]. It carries the request's byte enables, write flag and write data.
- R4: Size code 0 is 256MB (all 256 buses). Code 1 is 128MB and claims only when addr[27] is 0. Codes 2 and 3 are 64MB and claim only when addr[27:26] is 0. Addresses beyond the selected size are passed through.
- R5: A claimed memory request with addr[1:0] not zero is not delivered. It raises `o_reject` and gives no configuration request.
- R6: A memory request that misses the window, or that arrives while the window is disabled, raises `o_pass_valid`.
- R7: An I/O write with all four byte enables set to dword address 0xCF8 loads the latch from the write data and gives no output.
- R8: An I/O access to dword address 0xCFC while latch bit 31 is set gives a configuration request. Its fields are bus = latch[23:16], device = latch[15:11], function = latch[10:8] and register = {4'b0, latch[7:2], 2'b00}. Byte enables, write flag and data come from the request.
- R9: Other I/O requests are passed through. These are the 0xCFC dword with latch bit 31 clear, 0xCF8 reads, 0xCF8 writes with partial byte enables, and any other port.
- R10: Outputs appear in the cycle after the request. At most one of `o_cfg_valid`, `o_pass_valid` and `o_reject` is high, and none is high without a request in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_set | input | 1 | Load strobe for the window register |
| win_base | input | 36 | Proposed window base address |
| win_size | input | 2 | Window size code |
| win_en | input | 1 | Window enable to load |
| req_valid | input | 1 | Request present this cycle |
| req_is_io | input | 1 | 1 for I/O space, 0 for memory space |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Request byte address (dword address for I/O) |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| o_cfg_valid | output | 1 | Configuration request issued |
| o_cfg_bus | output | 8 | Bus number |
| o_cfg_dev | output | 5 | Device number |
| o_cfg_fn | output | 3 | Function number |
| o_cfg_reg | output | 12 | Register byte offset |
| o_cfg_be | output | 4 | Byte enables |
| o_cfg_write | output | 1 | Write flag |
| o_cfg_wdata | output | 32 | Write data |
| o_pass_valid | output | 1 | Request forwarded as an ordinary access |
| o_reject | output | 1 | Misaligned configuration access dropped |

## Verification
The hardest cases to reach from the ports are the window's edges. A memory address must match the base exactly, yet sit just past the bus limit of a 128MB or 64MB window. A latched port dword must also be used only after its enable bit has been changed by an earlier write. The stimulus draws most memory addresses from the currently programmed base, with random low bits, so hits, over-size misses and misaligned hits occur often. The size code and the base are re-programmed at random, sometimes with a misaligned base that must be ignored. Port writes and data-port accesses are interleaved so that latch contents with the enable bit both set and clear are exercised. Directed cases add the exact bus limits 0x7F/0x80 and 0x3F/0x40.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;

    localparam int WIN_LSB  = 28;
    localparam int BUS_W    = 8;
    localparam int DEV_W    = 5;
    localparam int FN_W     = 3;
    localparam int OFF_W    = 12;
    localparam logic [13:0] PORT_ADDR_DW = 14'h33E;  // 0xCF8 >> 2
    localparam logic [13:0] PORT_DATA_DW = 14'h33F;  // 0xCFC >> 2

    typedef enum logic [1:0] {
        SZ_256M = 2'd0,
        SZ_128M = 2'd1,
        SZ_64M  = 2'd2,
        SZ_64MB = 2'd3
    } win_size_e;

    typedef enum logic [1:0] {
        DEC_NONE   = 2'd0,
        DEC_CFG    = 2'd1,
        DEC_PASS   = 2'd2,
        DEC_REJECT = 2'd3
    } dec_kind_e;

    typedef struct packed {
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
        logic [FN_W-1:0]  fn;
        logic [OFF_W-1:0] off;
    } cfg_coord_t;

    // top two bus bits of the window address, tested against the size
    function automatic logic size_fits(win_size_e sz, logic [1:0] top);
        case (sz)
            SZ_256M: size_fits = 1'b1;
            SZ_128M: size_fits = ~top[1];
            default: size_fits = (top == 2'b00);
        endcase
    endfunction

    function automatic cfg_coord_t coord_from_window(logic [WIN_LSB-1:0] a);
        cfg_coord_t c;
        c.bus = a[27:20];
        c.dev = a[19:15];
        c.fn  = a[14:12];
        c.off = a[11:0];
        return c;
    endfunction

    function automatic cfg_coord_t coord_from_latch(logic [31:0] l);
        cfg_coord_t c;
        c.bus = l[23:16];
        c.dev = l[15:11];
        c.fn  = l[10:8];
        c.off = {4'b0000, l[7:2], 2'b00};
        return c;
    endfunction

endpackage

// File: rtl/cfgdec_winreg.sv
module cfgdec_winreg
    import cfgdec_pkg::*;
#(
    parameter int BASE_W = 36,
    localparam int HI_W  = BASE_W - WIN_LSB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set,
    input  logic [BASE_W-1:0] base_in,
    input  logic [1:0]        size_in,
    input  logic              en_in,
    output logic [HI_W-1:0]   base_hi,
    output win_size_e         size,
    output logic              en
);

    logic aligned;
    assign aligned = (base_in[WIN_LSB-1:0] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_hi <= '0;
            size    <= SZ_256M;
            en      <= 1'b0;
        end else if (set && aligned) begin
            base_hi <= base_in[BASE_W-1:WIN_LSB];
            size    <= win_size_e'(size_in);
            en      <= en_in;
        end
    end

endmodule

// File: rtl/cfgdec_mem_dec.sv
module cfgdec_mem_dec
    import cfgdec_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int BASE_W = 36,
    localparam int HI_W  = BASE_W - WIN_LSB,
    localparam int AHI_W = ADDR_W - WIN_LSB
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [HI_W-1:0]   base_hi,
    input  win_size_e         size,
    input  logic              en,
    output dec_kind_e         kind,
    output cfg_coord_t        coord
);

    logic [AHI_W-1:0] base_ext;
    logic             hit;

    assign base_ext = AHI_W'(base_hi);
    assign hit      = en && (addr[ADDR_W-1:WIN_LSB] == base_ext)
                      && size_fits(size, addr[27:26]);
    assign coord    = coord_from_window(addr[WIN_LSB-1:0]);

    always_comb begin
        if (!hit)                   kind = DEC_PASS;
        else if (addr[1:0] != 2'b0) kind = DEC_REJECT;
        else                        kind = DEC_CFG;
    end

endmodule

// File: rtl/cfgdec_io_dec.sv
module cfgdec_io_dec
    import cfgdec_pkg::*;
#(
    parameter int ADDR_W = 40,
    localparam int DW_W  = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    input  logic [31:0]       wdata,
    output dec_kind_e         kind,
    output cfg_coord_t        coord
);

    logic [31:0] latch_q;
    logic        at_addr_port, at_data_port, latch_we;

    assign at_addr_port = (addr[ADDR_W-1:2] == DW_W'(PORT_ADDR_DW));
    assign at_data_port = (addr[ADDR_W-1:2] == DW_W'(PORT_DATA_DW));
    assign latch_we     = valid && write && at_addr_port && (be == 4'hF);
    assign coord        = coord_from_latch(latch_q);

    always_ff @(posedge clk) begin
        if (rst)           latch_q <= '0;
        else if (latch_we) latch_q <= wdata;
    end

    always_comb begin
        if (at_addr_port)      kind = (write && be == 4'hF) ? DEC_NONE : DEC_PASS;
        else if (at_data_port) kind = latch_q[31] ? DEC_CFG : DEC_PASS;
        else                   kind = DEC_PASS;
    end

endmodule

// File: rtl/cfgwin_decoder.sv
module cfgwin_decoder
    import cfgdec_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int BASE_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              win_set,
    input  logic [BASE_W-1:0] win_base,
    input  logic [1:0]        win_size,
    input  logic              win_en,
    input  logic              req_valid,
    input  logic              req_is_io,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic              o_cfg_valid,
    output logic [7:0]        o_cfg_bus,
    output logic [4:0]        o_cfg_dev,
    output logic [2:0]        o_cfg_fn,
    output logic [11:0]       o_cfg_reg,
    output logic [3:0]        o_cfg_be,
    output logic              o_cfg_write,
    output logic [31:0]       o_cfg_wdata,
    output logic              o_pass_valid,
    output logic              o_reject
);

    localparam int HI_W = BASE_W - WIN_LSB;

    logic [HI_W-1:0] base_hi;
    win_size_e       size;
    logic            en;
    dec_kind_e       mem_kind, io_kind, kind;
    cfg_coord_t      mem_coord, io_coord, coord;

    cfgdec_winreg #(.BASE_W(BASE_W)) u_win (
        .clk(clk), .rst(rst), .set(win_set), .base_in(win_base),
        .size_in(win_size), .en_in(win_en),
        .base_hi(base_hi), .size(size), .en(en)
    );

    cfgdec_mem_dec #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_mem (
        .addr(req_addr), .base_hi(base_hi), .size(size), .en(en),
        .kind(mem_kind), .coord(mem_coord)
    );

    cfgdec_io_dec #(.ADDR_W(ADDR_W)) u_io (
        .clk(clk), .rst(rst), .valid(req_valid && req_is_io),
        .write(req_write), .addr(req_addr), .be(req_be), .wdata(req_wdata),
        .kind(io_kind), .coord(io_coord)
    );

    assign kind  = req_is_io ? io_kind  : mem_kind;
    assign coord = req_is_io ? io_coord : mem_coord;

    always_ff @(posedge clk) begin
        if (rst) begin
            o_cfg_valid  <= 1'b0;
            o_pass_valid <= 1'b0;
            o_reject     <= 1'b0;
            o_cfg_bus    <= '0;
            o_cfg_dev    <= '0;
            o_cfg_fn     <= '0;
            o_cfg_reg    <= '0;
            o_cfg_be     <= '0;
            o_cfg_write  <= 1'b0;
            o_cfg_wdata  <= '0;
        end else begin
            o_cfg_valid  <= req_valid && (kind == DEC_CFG);
            o_pass_valid <= req_valid && (kind == DEC_PASS);
            o_reject     <= req_valid && (kind == DEC_REJECT);
            if (req_valid && kind == DEC_CFG) begin
                o_cfg_bus   <= coord.bus;
                o_cfg_dev   <= coord.dev;
                o_cfg_fn    <= coord.fn;
                o_cfg_reg   <= coord.off;
                o_cfg_be    <= req_be;
                o_cfg_write <= req_write;
                o_cfg_wdata <= req_wdata;
            end
        end
    end

endmodule

// File: rtl/cfgdec_chk.sv
module cfgdec_chk #(
    parameter int ADDR_W = 40
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_is_io,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [3:0]        req_be,
    input logic              o_cfg_valid,
    input logic [11:0]       o_cfg_reg,
    input logic              o_pass_valid,
    input logic              o_reject
);

    // R10
    single_result_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({o_cfg_valid, o_pass_valid, o_reject}));

    // R10
    result_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        (o_cfg_valid || o_pass_valid || o_reject) |-> $past(req_valid));

    // R5
    misaligned_mem_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_is_io && req_addr[1:0] != 2'b00) |=> !o_cfg_valid);

    // R8
    port_offset_range_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_is_io) |=> (!o_cfg_valid || o_cfg_reg[11:8] == 4'h0));

    // R7
    latch_write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_is_io && req_write && req_be == 4'hF
         && req_addr == ADDR_W'(32'hCF8))
        |=> !(o_cfg_valid || o_pass_valid || o_reject));

endmodule

bind cfgwin_decoder cfgdec_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_io(req_is_io),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .o_cfg_valid(o_cfg_valid), .o_cfg_reg(o_cfg_reg),
    .o_pass_valid(o_pass_valid), .o_reject(o_reject)
);

// File: tb/sim_cfgwin_decoder.sv
module sim_cfgwin_decoder;

    localparam int AW = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic win_set = 1'b0;
    logic [35:0] win_base = '0;
    logic [1:0] win_size = '0;
    logic win_en = 1'b0;
    logic req_valid = 1'b0, req_is_io = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0] req_be = '0;
    logic [31:0] req_wdata = '0;
    logic o_cfg_valid, o_cfg_write, o_pass_valid, o_reject;
    logic [7:0] o_cfg_bus;
    logic [4:0] o_cfg_dev;
    logic [2:0] o_cfg_fn;
    logic [11:0] o_cfg_reg;
    logic [3:0] o_cfg_be;
    logic [31:0] o_cfg_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    logic [7:0] m_hi = '0;
    logic [1:0] m_size = '0;
    logic m_en = 1'b0;
    logic [31:0] m_latch = '0;

    always #5 clk = ~clk;

    cfgwin_decoder u0 (.*);

    task automatic program_win(input logic [35:0] b, input logic [1:0] s, input logic e);
        win_set = 1'b1; win_base = b; win_size = s; win_en = e;
        @(negedge clk);
        win_set = 1'b0;
        if (b[27:0] == 28'h0) begin
            m_hi = b[35:28]; m_size = s; m_en = e;
        end
    endtask

    // kind: 0 none, 1 cfg, 2 pass, 3 reject
    task automatic req(input logic io, input logic wr, input logic [AW-1:0] a,
                       input logic [3:0] be, input logic [31:0] wd, input string note);
        int kind;
        string tag;
        logic [7:0] eb; logic [4:0] ed; logic [2:0] ef; logic [11:0] er;
        logic fits;
        eb = '0; ed = '0; ef = '0; er = '0;
        if (io) begin
            if (a == AW'(32'hCF8)) begin
                if (wr && be == 4'hF) begin kind = 0; tag = "R7"; end
                else begin kind = 2; tag = "R9"; end
            end else if (a == AW'(32'hCFC)) begin
                if (m_latch[31]) begin
                    kind = 1; tag = "R8";
                    eb = m_latch[23:16]; ed = m_latch[15:11]; ef = m_latch[10:8];
                    er = {4'h0, m_latch[7:2], 2'b00};
                end else begin kind = 2; tag = "R9"; end
            end else begin kind = 2; tag = "R9"; end
        end else begin
            fits = (m_size == 2'd0) || (m_size == 2'd1 && !a[27]) ||
                   (m_size >= 2'd2 && a[27:26] == 2'b00);
            if (m_en && a[39:28] == {4'h0, m_hi} && fits) begin
                if (a[1:0] != 2'b00) begin kind = 3; tag = "R5"; end
                else begin
                    kind = 1; tag = (m_size == 2'd0) ? "R3" : "R4";
                    eb = a[27:20]; ed = a[19:15]; ef = a[14:12]; er = a[11:0];
                end
            end else begin
                kind = 2; tag = (m_en && a[39:28] == {4'h0, m_hi}) ? "R4" : "R6";
            end
        end
        req_valid = 1'b1; req_is_io = io; req_write = wr; req_addr = a;
        req_be = be; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        checks++;
        if (o_cfg_valid !== (kind == 1) || o_pass_valid !== (kind == 2) ||
            o_reject !== (kind == 3)) begin
            errors++;
            $display("FAIL %s (%s) addr=%h: cfg/pass/rej=%b%b%b expected kind %0d (R10)",
                     tag, note, a, o_cfg_valid, o_pass_valid, o_reject, kind);
        end else if (kind == 1 &&
            (o_cfg_bus !== eb || o_cfg_dev !== ed || o_cfg_fn !== ef || o_cfg_reg !== er ||
             o_cfg_be !== be || o_cfg_write !== wr || (wr && o_cfg_wdata !== wd))) begin
            errors++;
            $display("FAIL %s (%s) addr=%h: got %h/%h/%h/%h be %h w %b, expected %h/%h/%h/%h be %h w %b",
                     tag, note, a, o_cfg_bus, o_cfg_dev, o_cfg_fn, o_cfg_reg, o_cfg_be,
                     o_cfg_write, eb, ed, ef, er, be, wr);
        end
        if (io && wr && be == 4'hF && a == AW'(32'hCF8)) m_latch = wd;
    endtask

    function automatic logic [AW-1:0] coord_addr(input logic [7:0] hi, input logic [7:0] b,
        input logic [4:0] d, input logic [2:0] f, input logic [11:0] o);
        return {4'h0, hi, b, d, f, o};
    endfunction

    initial begin
        int unsigned seedv;
        seedv = $urandom(32'h5eed1234);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        req(1'b0, 1'b0, coord_addr(8'h00, 8'h00, 5'd0, 3'd0, 12'h000), 4'hF, 0, "R1 window off");
        req(1'b1, 1'b0, AW'(32'hCFC), 4'hF, 0, "R1 latch off");
        // R2: misaligned base ignored
        program_win(36'h1_2345_6000, 2'd0, 1'b1);
        req(1'b0, 1'b0, coord_addr(8'h12, 8'h01, 5'd0, 3'd0, 12'h000), 4'hF, 0, "R2 ignored");
        program_win(36'h8_F000_0000, 2'd0, 1'b1);
        req(1'b0, 1'b1, coord_addr(8'h8F, 8'h05, 5'd3, 3'd2, 12'h100), 4'h3, 32'hCAFE_0001, "R2 R3 hit");
        req(1'b0, 1'b0, coord_addr(8'h8F, 8'hFF, 5'd31, 3'd7, 12'hFFC), 4'hF, 0, "R3 top");
        req(1'b0, 1'b0, coord_addr(8'h8F, 8'h05, 5'd3, 3'd2, 12'h101), 4'hF, 0, "R5 misaligned");
        req(1'b0, 1'b0, coord_addr(8'h8E, 8'h05, 5'd3, 3'd2, 12'h100), 4'hF, 0, "R6 miss");
        program_win(36'h8_F000_0000, 2'd1, 1'b1);
        req(1'b0, 1'b0, coord_addr(8'h8F, 8'h7F, 5'd0, 3'd0, 12'h000), 4'hF, 0, "R4 128 last");
        req(1'b0, 1'b0, coord_addr(8'h8F, 8'h80, 5'd0, 3'd0, 12'h000), 4'hF, 0, "R4 128 beyond");
        program_win(36'h8_F000_0000, 2'd2, 1'b1);
        req(1'b0, 1'b0, coord_addr(8'h8F, 8'h3F, 5'd1, 3'd1, 12'h010), 4'hF, 0, "R4 64 last");
        req(1'b0, 1'b0, coord_addr(8'h8F, 8'h40, 5'd1, 3'd1, 12'h010), 4'hF, 0, "R4 64 beyond");
        program_win(36'h8_F000_0000, 2'd0, 1'b0);
        req(1'b0, 1'b0, coord_addr(8'h8F, 8'h05, 5'd3, 3'd2, 12'h100), 4'hF, 0, "R6 disabled");
        // port path
        req(1'b1, 1'b1, AW'(32'hCF8), 4'hF, 32'h8001_1A08, "R7 latch");
        req(1'b1, 1'b0, AW'(32'hCFC), 4'h4, 0, "R8 read");
        req(1'b1, 1'b1, AW'(32'hCFC), 4'hF, 32'h1234_5678, "R8 write");
        req(1'b1, 1'b1, AW'(32'hCF8), 4'h3, 32'h0000_0000, "R9 partial");
        req(1'b1, 1'b0, AW'(32'hCFC), 4'hF, 0, "R8 latch kept");
        req(1'b1, 1'b0, AW'(32'hCF8), 4'hF, 0, "R9 latch read");
        req(1'b1, 1'b0, AW'(32'hCF4), 4'hF, 0, "R9 other port");
        req(1'b1, 1'b1, AW'(32'hCF8), 4'hF, 32'h0001_1A08, "R7 disable");
        req(1'b1, 1'b0, AW'(32'hCFC), 4'hF, 0, "R9 latch off");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int unsigned op;
            op = $urandom % 16;
            if (op == 0) begin
                logic [35:0] b;
                b = {$urandom % 256, 28'h0};
                if ($urandom % 5 == 0) b[27:0] = 28'($urandom) | 28'h10;
                program_win(b[35:0], 2'($urandom), ($urandom % 8) != 0);
            end else if (op <= 2) begin
                logic [31:0] d;
                d = $urandom;
                req(1'b1, 1'b1, AW'(32'hCF8), ($urandom % 4 == 0) ? 4'($urandom) : 4'hF, d, "rnd latch");
            end else if (op <= 5) begin
                req(1'b1, 1'($urandom), AW'(32'hCFC), 4'($urandom), $urandom, "rnd data port");
            end else if (op == 6) begin
                req(1'b1, 1'($urandom), AW'(32'hC00 + 4 * ($urandom % 256)), 4'hF, $urandom, "rnd port");
            end else begin
                logic [AW-1:0] a;
                logic [7:0] hi;
                hi = ($urandom % 4 == 0) ? 8'($urandom) : m_hi;
                a = {($urandom % 8 == 0) ? 4'($urandom) : 4'h0, hi, 28'($urandom)};
                if ($urandom % 8 != 0) a[1:0] = 2'b00;
                req(1'b0, 1'($urandom), a, 4'($urandom), $urandom, "rnd mem");
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule